// File: doc/BRIEF.md
# Region Read-Modify-Write Memory Controller

This controller connects a processor's single-word request port to a non-volatile memory that has two limits. It reads one 16-bit word per access after a fixed delay. It accepts writes only as complete aligned regions of 128 words. A read request is forwarded to the memory as one word access. A write request becomes a sequence of three steps: the controller loads the whole region that holds the target word into a local buffer, puts the new word into that buffer, and then sends the complete region back through the commit port.

The request port uses a valid/ready handshake and serves one request at a time. Both memory delays are parameters counted in clock cycles: `RD_LAT` for one word read and `CM_LAT` for the commit window. The controller counts these delays itself, because the memory gives no handshake. A write therefore finishes 128·`RD_LAT` + `CM_LAT` cycles after it is accepted. The parameters must satisfy `RD_LAT` ≥ 2 and `CM_LAT` ≥ `WORDS` + 2, so that the whole region is streamed out while the commit window is still open.

Top module: `nvm_region_rmw`

## Requirements
- R1: After reset, `req_ready` is 1. `mem_rd_en`, `mem_cm_start`, `mem_cm_busy`, `mem_cm_wen`, `rsp_rvalid` and `rsp_wdone` are all 0.
- R2: A read request (`req_we`=0) produces exactly one memory read of `req_addr`. It produces no commit activity. `rsp_rvalid` is a one-cycle pulse that rises `RD_LAT` cycles after the accepting clock edge, with `rsp_rdata` equal to the memory word at `req_addr`.
- R3: `req_ready` falls at the accepting edge and stays low until the completion pulse. Requests presented while it is low have no effect on the memory or on the responses.
- R4: A write request issues exactly `WORDS` single-word reads. Their addresses run in ascending order from the region base, which is `req_addr` with its low log2(`WORDS`) bits cleared. Successive reads are spaced exactly `RD_LAT` cycles apart.
- R5: After a write, the region holds its previous contents, except the word at offset `req_addr[6:0]`, which holds `req_wdata`.
- R6: A write gives one `mem_cm_start` pulse carrying the region base in `mem_cm_base`. `mem_cm_busy` stays high for exactly `CM_LAT` cycles. Inside that window, `WORDS` word transfers appear on `mem_cm_wen`, with offsets 0 to `WORDS`-1 in order. No word read takes place while the commit is busy.
- R7: `rsp_wdone` is a one-cycle pulse that rises 128·`RD_LAT` + `CM_LAT` cycles after the accepting edge. `req_ready` returns high on that same cycle.
- R8: A write changes no memory word outside its own region, and this holds for target offsets 0 and 127 and for the first and the last region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be accepted |
| req_addr | input | AW | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Word to write |
| rsp_rdata | output | DW | Read result, held until the next read |
| rsp_rvalid | output | 1 | One-cycle read completion pulse |
| rsp_wdone | output | 1 | One-cycle write completion pulse |
| mem_rd_en | output | 1 | One-cycle word read command |
| mem_rd_addr | output | AW | Address of the word read |
| mem_rd_data | input | DW | Memory word, valid RD_LAT cycles after the command |
| mem_cm_start | output | 1 | One-cycle pulse opening a region commit |
| mem_cm_base | output | AW | Base address of the committed region |
| mem_cm_busy | output | 1 | Commit window open |
| mem_cm_wen | output | 1 | Region word transfer strobe |
| mem_cm_off | output | log2(WORDS) | Offset of the transferred word |
| mem_cm_data | output | DW | Transferred word |

## Verification
A wrong fetch index or a wrong merge condition does not stay hidden. It reaches the memory at the end of the very next write, where the committed region differs from the expected image in one word or more. The bench compares the whole memory after every write, so it also catches a stray write into another region. Errors in the latency counters or in the state machine show up as a shifted completion pulse, a busy window of the wrong length, or uneven spacing between fetch reads, and all of these are measured in whole cycles on the first transaction affected. Requests injected while the controller is busy would show up as extra reads or as a changed region.

// File: rtl/nvm_rmw_pkg.sv
package nvm_rmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD     = 2'd1,
    ST_FETCH  = 2'd2,
    ST_COMMIT = 2'd3
  } rmw_state_t;
endpackage

// File: rtl/rmw_lat_timer.sv
// Cycle counter: hit is high once limit cycles have passed since the last clear.
module rmw_lat_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!hit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rmw_region_buf.sv
// Region staging buffer: one synchronous write port, one registered read port.
module rmw_region_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import nvm_rmw_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int WORDS  = 128,
  parameter int OW     = $clog2(WORDS),
  parameter int RD_LAT = 125,
  parameter int CM_LAT = 64000,
  parameter int CW     = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_rvalid,
  output logic          rsp_wdone,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_cm_start,
  output logic [AW-1:0] mem_cm_base,
  output logic          mem_cm_busy,
  output logic          mem_cm_wen,
  output logic [OW-1:0] mem_cm_off,
  // timer
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_limit,
  input  logic          tmr_hit,
  // buffer
  output logic          buf_we,
  output logic [OW-1:0] buf_waddr,
  output logic [DW-1:0] buf_wdata,
  output logic          buf_re,
  output logic [OW-1:0] buf_raddr
);
  localparam int BW = AW - OW;
  localparam logic [OW-1:0] LAST = OW'(WORDS - 1);

  rmw_state_t    state;
  logic [BW-1:0] base_q;
  logic [OW-1:0] off_q;
  logic [DW-1:0] wdata_q;
  logic [OW-1:0] widx;
  logic          s_act;
  logic [OW-1:0] s_cnt;
  logic          fetch_hit;

  assign fetch_hit = (state == ST_FETCH) && tmr_hit;

  // timer control
  assign tmr_clr   = ((state == ST_IDLE) && req_valid) || fetch_hit;
  assign tmr_limit = (state == ST_COMMIT) ? CW'(CM_LAT) : CW'(RD_LAT);

  // fetch writes each arriving word, merged with the new data at the target offset
  assign buf_we    = fetch_hit;
  assign buf_waddr = widx;
  assign buf_wdata = (widx == off_q) ? wdata_q : mem_rd_data;
  assign buf_re    = s_act;
  assign buf_raddr = s_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      req_ready    <= 1'b1;
      rsp_rdata    <= '0;
      rsp_rvalid   <= 1'b0;
      rsp_wdone    <= 1'b0;
      mem_rd_en    <= 1'b0;
      mem_rd_addr  <= '0;
      mem_cm_start <= 1'b0;
      mem_cm_base  <= '0;
      mem_cm_busy  <= 1'b0;
      mem_cm_wen   <= 1'b0;
      mem_cm_off   <= '0;
      base_q       <= '0;
      off_q        <= '0;
      wdata_q      <= '0;
      widx         <= '0;
      s_act        <= 1'b0;
      s_cnt        <= '0;
    end else begin
      mem_rd_en    <= 1'b0;
      mem_cm_start <= 1'b0;
      rsp_rvalid   <= 1'b0;
      rsp_wdone    <= 1'b0;
      // commit stream pipeline: buffer read is one cycle ahead of the strobe
      mem_cm_wen   <= s_act;
      mem_cm_off   <= s_cnt;
      if (s_act) begin
        s_cnt <= s_cnt + 1'b1;
        if (s_cnt == LAST) s_act <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            mem_rd_en <= 1'b1;
            base_q    <= req_addr[AW-1:OW];
            off_q     <= req_addr[OW-1:0];
            wdata_q   <= req_wdata;
            widx      <= '0;
            if (req_we) begin
              state       <= ST_FETCH;
              mem_rd_addr <= {req_addr[AW-1:OW], {OW{1'b0}}};
            end else begin
              state       <= ST_RD;
              mem_rd_addr <= req_addr;
            end
          end
        end
        ST_RD: begin
          if (tmr_hit) begin
            rsp_rdata  <= mem_rd_data;
            rsp_rvalid <= 1'b1;
            req_ready  <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_FETCH: begin
          if (tmr_hit) begin
            if (widx == LAST) begin
              state        <= ST_COMMIT;
              mem_cm_start <= 1'b1;
              mem_cm_busy  <= 1'b1;
              mem_cm_base  <= {base_q, {OW{1'b0}}};
              s_act        <= 1'b1;
              s_cnt        <= '0;
            end else begin
              widx        <= widx + 1'b1;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= {base_q, widx + 1'b1};
            end
          end
        end
        ST_COMMIT: begin
          if (tmr_hit) begin
            mem_cm_busy <= 1'b0;
            rsp_wdone   <= 1'b1;
            req_ready   <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_region_rmw.sv
module nvm_region_rmw #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int WORDS  = 128,
  parameter int RD_LAT = 125,
  parameter int CM_LAT = 64000,
  localparam int OW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_rvalid,
  output logic          rsp_wdone,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_cm_start,
  output logic [AW-1:0] mem_cm_base,
  output logic          mem_cm_busy,
  output logic          mem_cm_wen,
  output logic [OW-1:0] mem_cm_off,
  output logic [DW-1:0] mem_cm_data
);
  localparam int LMAX = (RD_LAT > CM_LAT) ? RD_LAT : CM_LAT;
  localparam int CW   = $clog2(LMAX + 1);

  logic          tmr_clr, tmr_hit;
  logic [CW-1:0] tmr_limit;
  logic          buf_we, buf_re;
  logic [OW-1:0] buf_waddr, buf_raddr;
  logic [DW-1:0] buf_wdata;

  rmw_fsm #(
    .AW(AW), .DW(DW), .WORDS(WORDS), .OW(OW),
    .RD_LAT(RD_LAT), .CM_LAT(CM_LAT), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_wdone(rsp_wdone),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_cm_start(mem_cm_start), .mem_cm_base(mem_cm_base), .mem_cm_busy(mem_cm_busy),
    .mem_cm_wen(mem_cm_wen), .mem_cm_off(mem_cm_off),
    .tmr_clr(tmr_clr), .tmr_limit(tmr_limit), .tmr_hit(tmr_hit),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_re(buf_re), .buf_raddr(buf_raddr)
  );

  rmw_lat_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .limit(tmr_limit), .hit(tmr_hit)
  );

  rmw_region_buf #(.DW(DW), .DEPTH(WORDS), .IW(OW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .re(buf_re), .raddr(buf_raddr), .rdata(mem_cm_data)
  );
endmodule

// File: rtl/nvm_region_rmw_chk.sv
module nvm_region_rmw_chk #(
  parameter int CM_LAT = 64000,
  parameter int OW     = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_rvalid,
  input logic          rsp_wdone,
  input logic          mem_rd_en,
  input logic          mem_cm_start,
  input logic          mem_cm_busy,
  input logic          mem_cm_wen,
  input logic [OW-1:0] mem_cm_off
);
  localparam int BCW = $clog2(CM_LAT + 2);
  logic [BCW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)              busy_len <= '0;
    else if (mem_cm_busy) busy_len <= busy_len + 1'b1;
    else                  busy_len <= '0;
  end

  // R1: memory commands only issued while a request is in progress
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(mem_rd_en || mem_cm_start || mem_cm_busy || mem_cm_wen));

  // R2: read completion is a single-cycle pulse, never coincident with write done
  a_r2_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_rvalid |=> !rsp_rvalid);

  a_r2_one_kind_done: assert property (@(posedge clk) disable iff (rst)
    !(rsp_rvalid && rsp_wdone));

  // R3: accepting a request drops ready on the next cycle
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6: no word read during the commit window; transfers stay inside it
  a_r6_no_read_in_commit: assert property (@(posedge clk) disable iff (rst)
    mem_cm_busy |-> !mem_rd_en);

  a_r6_wen_inside_busy: assert property (@(posedge clk) disable iff (rst)
    mem_cm_wen |-> mem_cm_busy);

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_cm_start |=> !mem_cm_start);

  a_r6_offsets_ascend: assert property (@(posedge clk) disable iff (rst)
    (mem_cm_wen && $past(mem_cm_wen)) |-> (mem_cm_off == $past(mem_cm_off) + 1'b1));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cm_busy) |-> (busy_len == BCW'(CM_LAT)));

  // R7: write done is a single-cycle pulse with ready restored
  a_r7_wdone_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_wdone |-> (req_ready && !mem_cm_busy));
endmodule

bind nvm_region_rmw nvm_region_rmw_chk #(.CM_LAT(CM_LAT), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_rvalid(rsp_rvalid), .rsp_wdone(rsp_wdone), .mem_rd_en(mem_rd_en),
  .mem_cm_start(mem_cm_start), .mem_cm_busy(mem_cm_busy),
  .mem_cm_wen(mem_cm_wen), .mem_cm_off(mem_cm_off)
);

// File: tb/sim_nvm_region_rmw.sv
`timescale 1ns/1ps
module sim_nvm_region_rmw;
  localparam int AW     = 12;
  localparam int DW     = 16;
  localparam int WORDS  = 128;
  localparam int OW     = 7;
  localparam int RD_LAT = 3;
  localparam int CM_LAT = 140;
  localparam int MSIZE  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_we = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_rvalid, rsp_wdone;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic          mem_cm_start;
  logic [AW-1:0] mem_cm_base;
  logic          mem_cm_busy, mem_cm_wen;
  logic [OW-1:0] mem_cm_off;
  logic [DW-1:0] mem_cm_data;

  always #4 clk = ~clk; // 125 MHz

  nvm_region_rmw #(.AW(AW), .DW(DW), .WORDS(WORDS), .RD_LAT(RD_LAT), .CM_LAT(CM_LAT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_wdone(rsp_wdone),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_cm_start(mem_cm_start), .mem_cm_base(mem_cm_base), .mem_cm_busy(mem_cm_busy),
    .mem_cm_wen(mem_cm_wen), .mem_cm_off(mem_cm_off), .mem_cm_data(mem_cm_data)
  );

  // memory model and expected image
  logic [DW-1:0] nvm [MSIZE];
  logic [DW-1:0] exp_mem [MSIZE];
  logic [AW-1:0] rd_hold = '0;
  assign mem_rd_data = nvm[rd_hold];

  function automatic logic [DW-1:0] seed_word(input int i);
    return DW'(i * 40503) ^ 16'h5A5A;
  endfunction

  function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a);
    return {a[AW-1:OW], {OW{1'b0}}};
  endfunction

  int nvec = 0, nfail = 0;
  int cyc = 0;
  int n_rd, rd_err, gap_err, last_rd, n_cs, n_cw, cw_err, busy_cyc;
  logic [AW-1:0] exp_rd_base, cs_base;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) begin
      rd_hold <= mem_rd_addr;
      if (mem_rd_addr != exp_rd_base + AW'(n_rd)) rd_err++;
      if (n_rd > 0 && (cyc - last_rd) != RD_LAT) gap_err++;
      last_rd = cyc;
      n_rd++;
    end
    if (mem_cm_start) begin
      n_cs++;
      cs_base = mem_cm_base;
    end
    if (mem_cm_busy) busy_cyc++;
    if (mem_cm_wen) begin
      if (int'(mem_cm_off) != n_cw) cw_err++;
      nvm[cs_base | AW'(mem_cm_off)] <= mem_cm_data;
      n_cw++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit inject);
    int acc, waited, early;
    bit got;
    n_rd = 0; rd_err = 0; gap_err = 0; last_rd = 0; n_cs = 0; n_cw = 0; cw_err = 0;
    busy_cyc = 0;
    exp_rd_base = we ? base_of(a) : a;
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready high when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R3 ready low after accept", req_ready, 0);
    waited = 0; early = 0; got = 0;
    while (!got && waited < 4000) begin
      if (inject && waited == 3) begin
        req_valid = 1'b1; req_addr = a ^ 12'h800; req_we = 1'b1; req_wdata = ~d;
      end
      if (inject && waited == 6) req_valid = 1'b0;
      @(negedge clk);
      waited++;
      got = we ? rsp_wdone : rsp_rvalid;
      if (!got && req_ready) early++;
    end
    req_valid = 1'b0;
    chk(got, "R7/R2 completion seen", got, 1);
    chk(early == 0, "R3 ready stays low while busy", early, 0);
    chk(req_ready == 1'b1, "R7/R2 ready back at completion", req_ready, 1);
    if (we) begin
      chk(cyc - acc == 128 * RD_LAT + CM_LAT, "R7 write latency", cyc - acc, 128 * RD_LAT + CM_LAT);
      chk(n_rd == WORDS, "R4 fetch read count", n_rd, WORDS);
      chk(rd_err == 0, "R4 fetch addresses", rd_err, 0);
      chk(gap_err == 0, "R4 fetch spacing", gap_err, 0);
      chk(n_cs == 1, "R6 commit start count", n_cs, 1);
      chk(cs_base == base_of(a), "R6 commit base", cs_base, base_of(a));
      chk(n_cw == WORDS, "R6 commit word count", n_cw, WORDS);
      chk(cw_err == 0, "R6 commit offset order", cw_err, 0);
      chk(busy_cyc == CM_LAT, "R6 busy length", busy_cyc, CM_LAT);
      exp_mem[a] = d;
    end else begin
      chk(cyc - acc == RD_LAT, "R2 read latency", cyc - acc, RD_LAT);
      chk(rsp_rdata == exp_mem[a], "R2 read data", rsp_rdata, exp_mem[a]);
      chk(n_rd == 1 && rd_err == 0, "R2 single read of address", n_rd, 1);
      chk(n_cs == 0 && n_cw == 0, "R2 no commit on read", n_cs + n_cw, 0);
    end
    @(negedge clk);
    chk(!rsp_rvalid && !rsp_wdone, "R2/R7 completion is one cycle", rsp_rvalid | rsp_wdone, 0);
    if (we) begin
      int bad_r, bad_o;
      bad_r = 0; bad_o = 0;
      for (int i = 0; i < MSIZE; i++) begin
        if (nvm[i] !== exp_mem[i]) begin
          if (base_of(AW'(i)) == base_of(a)) bad_r++;
          else bad_o++;
        end
      end
      chk(bad_r == 0, "R5 region merged", bad_r, 0);
      chk(bad_o == 0, "R8 other regions untouched", bad_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < MSIZE; i++) begin
      nvm[i] = seed_word(i);
      exp_mem[i] = seed_word(i);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_cm_start && !mem_cm_busy && !mem_cm_wen
        && !rsp_rvalid && !rsp_wdone, "R1 reset state", req_ready, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_cm_busy && !rsp_rvalid && !rsp_wdone,
        "R1 idle after reset", req_ready, 1);

    // directed corners
    run_op(1'b0, 12'h005, '0, 1'b0);
    run_op(1'b1, 12'h000, 16'hA001, 1'b0);   // R8 offset 0, first region
    run_op(1'b1, 12'hFFF, 16'hB07F, 1'b0);   // R8 offset 127, last region
    run_op(1'b0, 12'h000, '0, 1'b0);
    run_op(1'b0, 12'hFFF, '0, 1'b0);
    run_op(1'b1, 12'h000, 16'hC002, 1'b1);   // R3 injected requests while busy
    run_op(1'b1, 12'h2C7, 16'h1234, 1'b0);
    run_op(1'b1, 12'h2C7, 16'h4321, 1'b0);   // same word twice
    run_op(1'b0, 12'h2C7, '0, 1'b1);
    run_op(1'b0, 12'h2C6, '0, 1'b0);

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, MSIZE - 1));
      if ($urandom_range(0, 1) == 1) run_op(1'b1, ra, DW'($urandom), k[2]);
      else run_op(1'b0, ra, '0, k[1]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule